// File: doc/BRIEF.md
# Scanned Keyboard and Display Controller

The controller refreshes a multiplexed character display from a 16-byte internal display RAM and, using the same scan count, reads a matrix of keys through return lines. It shows one character position per scan step on a single scan bus. While that position is shown, the return lines of the matching keyboard row are read. Keys that pass debouncing are turned into 6-bit codes and queued in an eight-entry FIFO. An interrupt output stays asserted while that FIFO holds a code.

The host has four controls. A mode-set command selects the display size and entry direction and the keyboard scan style and key policy. A second write sets the scan step length. Character writes fill the display RAM. A read strobe takes the oldest key code from the FIFO. A mode-set command also clears the display RAM, the entry position, the key tracking state and the overrun flag. It does not flush the FIFO.

Top module: `keyscan_disp_ctrl`

## Requirements
- R1: After reset the scan output is 0 (encoded), the display output is 0, irq_o and overrun_o are low, and the mode is 8 characters, left entry, encoded scan with 2-key lockout.
- R2: Mode-set word bits [1:0] are the display field: bit 0 = 1 selects 16 positions, otherwise 8. In encoded scan (keyboard field bit 2 of the word = 0) scan_o carries the binary position count. The count wraps to 0 after position 7 or 15.
- R3: Keyboard field = word bits [4:2]; its low bit (word bit 2) = 1 selects decoded scan. In decoded scan scan_o drives one-of-four active-low lines in the order 1110, 1101, 1011, 0111, and only positions 0 to 3 are scanned.
- R4: disp_o shows the display RAM byte of the position currently on the scan output.
- R5: With display field bit 1 = 0 (left entry), successive writes fill positions 0, 1, 2 and so on. After the last position of the selected size the next write goes to position 0.
- R6: With display field bit 1 = 1 (right entry), each write moves every character one position toward 0 within the selected size. The new character goes into the last position.
- R7: A key enters the FIFO only when it is seen closed (return line low) on two successive visits of its row. A closure seen on a single visit is ignored.
- R8: A key code is {row[2:0], column[2:0]}. The row is the scan position (0 to 7) and the column is the index of the return line. When several keys of one row qualify, the lowest column is entered first, one per visit. Codes leave the FIFO oldest first, and a held key is entered only once.
- R9: With keyboard field bit 1 = 0 (2-key lockout), no key is entered while any previously entered key is still held.
- R10: With keyboard field bit 1 = 1 (N-key rollover), a new key is entered while other entered keys are still held.
- R11: The FIFO holds 8 codes. A code arriving when it is full is dropped and sets overrun_o, which stays set until the next mode-set command.
- R12: irq_o is high whenever the FIFO holds at least one code and falls only after the read that empties it.
- R13: A write of div_i sets the scan step length to div_i + 1 clock cycles. The reset value is 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Mode-set strobe |
| cmd_mode_i | input | 5 | Mode word: [4:2] keyboard field, [1:0] display field |
| div_we_i | input | 1 | Scan step length write strobe |
| div_i | input | 8 | Scan step length minus one |
| disp_we_i | input | 1 | Display character write strobe |
| disp_data_i | input | 8 | Character to enter |
| key_rd_i | input | 1 | Pops the oldest key code |
| key_code_o | output | 6 | Oldest key code {row, column} |
| irq_o | output | 1 | FIFO not empty |
| overrun_o | output | 1 | Sticky FIFO overrun flag |
| scan_o | output | 4 | Scan lines: binary count or one-of-four active low |
| ret_i | input | 8 | Return lines, low = key closed |
| disp_o | output | 8 | Character data for the scanned position |

## Verification
The hardest state to reach from the ports is a key closure that lasts exactly one row visit. The bench models the key matrix itself: it drives the return lines from whatever row is on the scan output. It closes a key at the first sample where its row appears and opens it as soon as the row changes, so the closure is sampled exactly once. The overrun case is reached in a similar way. Nine keys are closed at the start of row 0 under rollover, so the ninth qualifies one pass after the FIFO fills.

// File: rtl/kd_pkg.sv
package kd_pkg;
  typedef struct packed {
    logic [2:0] kbd;   // [0] decoded scan, [1] n-key rollover, [2] unused here
    logic [1:0] disp;  // [0] 16 positions, [1] right entry
  } mode_t;
  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/kd_scan_timer.sv
module kd_scan_timer #(
  parameter int POS_W     = 4,
  parameter int NUM_POS   = 16,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             size16_i,
  input  logic             decoded_i,
  output logic             tick_o,
  output logic [POS_W-1:0] cnt_o,
  output logic [POS_W-1:0] scan_o
);
  logic [DIV_W-1:0] div_q, pre_q;
  logic [POS_W-1:0] cnt_q, last;

  assign last   = decoded_i ? POS_W'(3) :
                  size16_i  ? POS_W'(NUM_POS-1) : POS_W'(NUM_POS/2-1);
  assign tick_o = (pre_q == div_q) && !clr_i && !div_we_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_W'(DIV_RESET);
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (div_we_i) div_q <= div_i;
      if (clr_i || div_we_i || tick_o) pre_q <= '0;
      else                             pre_q <= pre_q + 1'b1;
      if (clr_i)       cnt_q <= '0;
      else if (tick_o) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < POS_W; i++)
      scan_o[i] = decoded_i ? (cnt_q[1:0] != 2'(i)) : cnt_q[i];
  end
endmodule

// File: rtl/kd_disp_ram.sv
module kd_disp_ram #(
  parameter int POS_W   = 4,
  parameter int NUM_POS = 16,
  parameter int CHAR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              right_i,
  input  logic              size16_i,
  input  logic [POS_W-1:0]  rd_pos_i,
  output logic [CHAR_W-1:0] data_o
);
  logic [NUM_POS-1:0][CHAR_W-1:0] mem_q, shifted;
  logic [POS_W-1:0] wptr_q, last;

  assign last    = size16_i ? POS_W'(NUM_POS-1) : POS_W'(NUM_POS/2-1);
  assign shifted = {CHAR_W'(0), mem_q[NUM_POS-1:1]};
  assign data_o  = mem_q[rd_pos_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '0;
      wptr_q <= '0;
    end else if (clr_i) begin
      mem_q  <= '0;
      wptr_q <= '0;
    end else if (we_i) begin
      for (int p = 0; p < NUM_POS; p++) begin
        if (right_i) begin
          if (POS_W'(p) == last)     mem_q[p] <= data_i;
          else if (POS_W'(p) < last) mem_q[p] <= shifted[p];
        end else if (POS_W'(p) == wptr_q) begin
          mem_q[p] <= data_i;
        end
      end
      if (!right_i) wptr_q <= (wptr_q == last) ? '0 : wptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/kd_key_detect.sv
module kd_key_detect #(
  parameter int POS_W    = 4,
  parameter int KEY_ROWS = 8,
  parameter int NUM_RET  = 8,
  localparam int ROW_W   = $clog2(KEY_ROWS),
  localparam int RET_W   = $clog2(NUM_RET)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   tick_i,
  input  logic [POS_W-1:0]       pos_i,
  input  logic [NUM_RET-1:0]     ret_i,
  input  logic                   lockout_i,
  output logic                   push_o,
  output logic [ROW_W+RET_W-1:0] code_o
);
  logic [KEY_ROWS-1:0][NUM_RET-1:0] seen_q, acc_q;
  logic [ROW_W-1:0]   row;
  logic [RET_W-1:0]   col;
  logic [NUM_RET-1:0] closed, cand, hot;
  logic               row_ok, blocked;

  assign row     = pos_i[ROW_W-1:0];
  assign row_ok  = pos_i < POS_W'(KEY_ROWS);
  assign closed  = ~ret_i;
  assign cand    = closed & seen_q[row] & ~acc_q[row];
  assign blocked = lockout_i && (|acc_q);
  assign push_o  = tick_i && row_ok && (|cand) && !blocked;
  assign code_o  = {row, col};
  assign hot     = push_o ? (NUM_RET'(1) << col) : '0;

  always_comb begin
    col = '0;
    for (int c = NUM_RET-1; c >= 0; c--)
      if (cand[c]) col = RET_W'(c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      acc_q  <= '0;
    end else if (clr_i) begin
      seen_q <= '0;
      acc_q  <= '0;
    end else if (tick_i && row_ok) begin
      seen_q[row] <= closed;
      acc_q[row]  <= (acc_q[row] & closed) | hot;
    end
  end
endmodule

// File: rtl/kd_key_fifo.sv
module kd_key_fifo #(
  parameter int WIDTH  = 6,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ovr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             not_empty_o,
  output logic             overrun_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, do_push, do_pop;

  assign full        = cnt_q == CNT_W'(DEPTH);
  assign not_empty_o = cnt_q != '0;
  assign do_push     = push_i && !full;
  assign do_pop      = pop_i && not_empty_o;
  assign head_o      = mem_q[rd_q];
  assign count_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rd_q      <= '0;
      wr_q      <= '0;
      cnt_q     <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (clr_ovr_i)           overrun_o <= 1'b0;
      else if (push_i && full) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/keyscan_disp_ctrl.sv
module keyscan_disp_ctrl #(
  parameter int CHAR_W     = 8,
  parameter int NUM_POS    = 16,
  parameter int KEY_ROWS   = 8,
  parameter int NUM_RET    = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 3,
  localparam int POS_W     = $clog2(NUM_POS),
  localparam int CODE_W    = $clog2(KEY_ROWS) + $clog2(NUM_RET),
  localparam int MODE_W    = kd_pkg::MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [MODE_W-1:0] cmd_mode_i,
  input  logic              div_we_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              disp_we_i,
  input  logic [CHAR_W-1:0] disp_data_i,
  input  logic              key_rd_i,
  output logic [CODE_W-1:0] key_code_o,
  output logic              irq_o,
  output logic              overrun_o,
  output logic [POS_W-1:0]  scan_o,
  input  logic [NUM_RET-1:0] ret_i,
  output logic [CHAR_W-1:0] disp_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  kd_pkg::mode_t    mode_q;
  logic             tick, push;
  logic [POS_W-1:0] pos;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0] fifo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (cmd_we_i) mode_q <= kd_pkg::mode_t'(cmd_mode_i);
  end

  kd_scan_timer #(.POS_W(POS_W), .NUM_POS(NUM_POS), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_timer (
    .clk_i, .rst_ni, .clr_i(cmd_we_i), .div_we_i, .div_i,
    .size16_i(mode_q.disp[0]), .decoded_i(mode_q.kbd[0]),
    .tick_o(tick), .cnt_o(pos), .scan_o);

  kd_disp_ram #(.POS_W(POS_W), .NUM_POS(NUM_POS), .CHAR_W(CHAR_W)) u_ram (
    .clk_i, .rst_ni, .clr_i(cmd_we_i), .we_i(disp_we_i && !cmd_we_i), .data_i(disp_data_i),
    .right_i(mode_q.disp[1]), .size16_i(mode_q.disp[0]), .rd_pos_i(pos), .data_o(disp_o));

  kd_key_detect #(.POS_W(POS_W), .KEY_ROWS(KEY_ROWS), .NUM_RET(NUM_RET)) u_keys (
    .clk_i, .rst_ni, .clr_i(cmd_we_i), .tick_i(tick), .pos_i(pos), .ret_i,
    .lockout_i(!mode_q.kbd[1]), .push_o(push), .code_o(code));

  kd_key_fifo #(.WIDTH(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_ovr_i(cmd_we_i), .push_i(push), .data_i(code), .pop_i(key_rd_i),
    .head_o(key_code_o), .not_empty_o(irq_o), .overrun_o, .count_o(fifo_cnt));
endmodule

module kd_ctrl_checker #(
  parameter int POS_W = 4,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_we_i,
  input logic             key_rd_i,
  input logic             irq_o,
  input logic             overrun_o,
  input logic [POS_W-1:0] scan_o,
  input logic [4:0]       mode_i,
  input logic [CNT_W-1:0] fifo_cnt_i
);
  a_r2_scan_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[2] && !mode_i[0]) |-> (scan_o < POS_W'(8)));
  a_r3_one_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[2] |-> ($countones(~scan_o) == 1));
  a_r11_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CNT_W'(DEPTH));
  a_r11_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !cmd_we_i) |=> overrun_o);
  a_r12_irq_falls_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(key_rd_i));
  a_r12_irq_matches_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (fifo_cnt_i != '0));
endmodule

bind keyscan_disp_ctrl kd_ctrl_checker #(.POS_W(POS_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cmd_we_i, .key_rd_i, .irq_o, .overrun_o, .scan_o,
  .mode_i(mode_q), .fifo_cnt_i(fifo_cnt));

// File: tb/sim_keyscan_disp_ctrl.sv
module sim_keyscan_disp_ctrl;
  logic clk_i = 0, rst_ni = 0;
  logic cmd_we_i = 0, div_we_i = 0, disp_we_i = 0, key_rd_i = 0;
  logic [4:0] cmd_mode_i = '0;
  logic [7:0] div_i = '0, disp_data_i = '0, disp_o, ret_i;
  logic [5:0] key_code_o;
  logic irq_o, overrun_o;
  logic [3:0] scan_o;

  logic [63:0] mat = '0;
  logic dec_mode = 0;
  logic mon_en = 0;
  logic [5:0] exp_q[$];
  int errors = 0, checks = 0, cycles = 0;

  always #10 clk_i = ~clk_i;

  keyscan_disp_ctrl u0 (.*);

  // key matrix model: return lines follow the scanned row
  always_comb begin
    ret_i = '1;
    if (dec_mode) begin
      for (int r = 0; r < 4; r++)
        if (scan_o == ~(4'b1 << r)) ret_i = ~mat[r*8 +: 8];
    end else if (scan_o < 4'd8) begin
      ret_i = ~mat[scan_o[2:0]*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk_i); cmd_mode_i = m; cmd_we_i = 1;
    @(negedge clk_i); cmd_we_i = 0;
    dec_mode = m[2];
  endtask

  task automatic put_char(input logic [7:0] d);
    @(negedge clk_i); disp_data_i = d; disp_we_i = 1;
    @(negedge clk_i); disp_we_i = 0;
  endtask

  task automatic wait_scan(input logic [3:0] v);
    do @(negedge clk_i); while (scan_o != v);
  endtask

  task automatic check_pos(input logic [3:0] p, input logic [7:0] exp, input string req);
    wait_scan(p);
    check(disp_o == exp, req, disp_o, exp);
  endtask

  task automatic step_len(output int n);
    logic [3:0] s;
    @(negedge clk_i); s = scan_o;
    do @(negedge clk_i); while (scan_o == s);
    s = scan_o; n = 0;
    do begin @(negedge clk_i); n++; end while (scan_o == s);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // scoreboard monitor: pops codes and compares with expected queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (mon_en && irq_o && !key_rd_i) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected key entered", key_code_o, 0);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          check(key_code_o == e, "R8 key code", key_code_o, e);
        end
        key_rd_i = 1;
      end else begin
        key_rd_i = 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        check(0, "watchdog", cycles, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int n;
    idle(3);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(scan_o == 4'd0 && disp_o == 8'd0, "R1 scan/display after reset", {scan_o, disp_o}, 0);
    check(!irq_o && !overrun_o, "R1 irq/overrun after reset", {irq_o, overrun_o}, 0);

    // R13 scan step length
    step_len(n);
    check(n == 4, "R13 reset step length", n, 4);
    @(negedge clk_i); div_i = 8'd1; div_we_i = 1;
    @(negedge clk_i); div_we_i = 0;
    step_len(n);
    check(n == 2, "R13 programmed step length", n, 2);

    // R2 wrap points
    set_mode(5'b00000);
    wait_scan(4'd7); do @(negedge clk_i); while (scan_o == 4'd7);
    check(scan_o == 4'd0, "R2 wrap after 8 positions", scan_o, 0);
    set_mode(5'b00001);
    wait_scan(4'd8);
    check(scan_o == 4'd8, "R2 16-position scan reaches 8", scan_o, 8);
    wait_scan(4'd15); do @(negedge clk_i); while (scan_o == 4'd15);
    check(scan_o == 4'd0, "R2 wrap after 16 positions", scan_o, 0);

    // R5 left entry, 8 positions, with wrap
    set_mode(5'b00000);
    for (int i = 0; i < 10; i++) put_char(8'hA0 + 8'(i));
    check_pos(4'd0, 8'hA8, "R5 left entry wrap pos0");
    check_pos(4'd1, 8'hA9, "R5 left entry wrap pos1");
    check_pos(4'd2, 8'hA2, "R4 R5 left entry pos2");
    check_pos(4'd7, 8'hA7, "R5 left entry pos7");

    // R6 right entry, 16 positions
    set_mode(5'b00011);
    put_char(8'hB0); put_char(8'hB1); put_char(8'hB2);
    check_pos(4'd15, 8'hB2, "R6 right entry last");
    check_pos(4'd14, 8'hB1, "R6 right entry shifted");
    check_pos(4'd13, 8'hB0, "R6 right entry oldest");
    check_pos(4'd12, 8'h00, "R6 right entry untouched");
    // R6 right entry, 8 positions, first char shifted out
    set_mode(5'b00010);
    for (int i = 0; i < 9; i++) put_char(8'hC0 + 8'(i));
    check_pos(4'd0, 8'hC1, "R6 right 8 pos0");
    check_pos(4'd7, 8'hC8, "R6 right 8 pos7");

    // key tests: 8 positions, encoded, 2-key lockout
    set_mode(5'b00000);
    mon_en = 1;
    // R7 single-visit closure ignored
    wait_scan(4'd4); mat[4*8+2] = 1;
    do @(negedge clk_i); while (scan_o == 4'd4);
    mat[4*8+2] = 0;
    idle(64);
    check(!irq_o && exp_q.size() == 0, "R7 bounce ignored", irq_o, 0);

    // R8 code format, R9 lockout
    exp_q.push_back(6'h13);
    mat[2*8+3] = 1;
    idle(64);
    check(exp_q.size() == 0, "R8 key (2,3) delivered", exp_q.size(), 0);
    mat[5*8+1] = 1;
    idle(64);
    check(!irq_o && exp_q.size() == 0, "R9 second key locked out", irq_o, 0);
    mat = '0; idle(48);

    // R10 rollover
    set_mode(5'b01000);
    exp_q.push_back(6'h13);
    mat[2*8+3] = 1; idle(64);
    exp_q.push_back(6'h29);
    mat[5*8+1] = 1; idle(64);
    check(exp_q.size() == 0, "R10 both keys entered", exp_q.size(), 0);
    // R8 lowest column first within one row
    exp_q.push_back(6'h30); exp_q.push_back(6'h34);
    mat[6*8+4] = 1; mat[6*8+0] = 1; idle(80);
    check(exp_q.size() == 0, "R8 same-row ordering", exp_q.size(), 0);
    mat = '0; idle(48);

    // R11 overrun, R12 interrupt
    set_mode(5'b01000);
    mon_en = 0;
    wait_scan(4'd0);
    for (int r = 0; r < 8; r++) mat[r*8] = 1;
    mat[1] = 1;
    idle(90);
    check(irq_o == 1, "R12 irq with queued keys", irq_o, 1);
    check(overrun_o == 1, "R11 overrun on ninth key", overrun_o, 1);
    for (int r = 0; r < 8; r++) exp_q.push_back(6'(r*8));
    mon_en = 1;
    idle(40);
    check(exp_q.size() == 0, "R11 eight codes kept", exp_q.size(), 0);
    check(irq_o == 0, "R12 irq low when empty", irq_o, 0);
    idle(64);
    check(overrun_o == 1 && !irq_o, "R11 sticky, dropped key not re-entered", {overrun_o, irq_o}, 2);
    mat = '0;
    set_mode(5'b00000);
    check(overrun_o == 0, "R11 overrun cleared by mode set", overrun_o, 0);

    // R3 decoded scan
    set_mode(5'b00100);
    wait_scan(4'b1110);
    do @(negedge clk_i); while (scan_o == 4'b1110);
    check(scan_o == 4'b1101, "R3 decoded line 1", scan_o, 4'b1101);
    do @(negedge clk_i); while (scan_o == 4'b1101);
    check(scan_o == 4'b1011, "R3 decoded line 2", scan_o, 4'b1011);
    do @(negedge clk_i); while (scan_o == 4'b1011);
    check(scan_o == 4'b0111, "R3 decoded line 3", scan_o, 4'b0111);
    do @(negedge clk_i); while (scan_o == 4'b0111);
    check(scan_o == 4'b1110, "R3 decoded wrap", scan_o, 4'b1110);
    exp_q.push_back(6'h1F);
    mat[3*8+7] = 1; idle(40);
    check(exp_q.size() == 0, "R3 R8 decoded key (3,7)", exp_q.size(), 0);
    mat = '0; idle(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule